// File: doc/BRIEF.md
# Serial Audio Link Output-Frame Receiver

This block sits on the codec side of a bit-serial audio link and turns the controller's outgoing serial stream into parallel words. The link runs on a single bit clock. The frame sync line is sampled on the rising edge of that clock. The serial data line is sampled on the falling edge that follows the rising edge on which the controller launched each bit. Each frame is 256 bits long: a 16-bit tag phase followed by twelve 20-bit slots, all sent MSB first.

The receiver keeps a bit counter anchored to the last frame start it accepted. A sync rise is accepted in two cases: when nothing is being tracked, or when it lands exactly on the 256-bit boundary. A rise inside a frame spoils that frame. Its data is dropped, and the counter keeps running until the next properly spaced start. Of the twelve slots only four are taken: a control address, control data, a left PCM sample and a right PCM sample. The rest are discarded.

Results of a frame that was checked and accepted appear together, one cycle after its last bit, each with a single-cycle strobe. The link cannot be stalled, so the outputs have no ready input. This is the stream rule for this block: whatever is downstream must take each strobe in the cycle it is high, because the next result can come only 256 cycles later.

Top module: `serial_link_frame_rx`

## Requirements
- R1: While reset is asserted and right after its release, every strobe is 0, the control and PCM outputs are 0, and no frame is being tracked.
- R2: A sync rise is found by comparing sync at a rising edge with its value at the previous rising edge. The first data bit sampled on the falling edge after the edge that found the rise is the frame-valid bit. For an accepted frame, the strobes are high in the cycle after the 257th rising edge counted from the edge that launched the sync rise.
- R3: Frame layout: bit 0 is frame-valid, and bit n (n = 1..12) is the tag of slot n. Bits 13 to 15 carry nothing used here. Slot n occupies bits 16+20(n-1) through 16+20(n-1)+19, and its first bit is the slot's MSB.
- R4: A sync rise that comes before bit 255 of the current frame has been taken is ignored as a frame start. The current frame produces no output, and bit counting continues from the last accepted start.
- R5: A sync rise is accepted as a frame start when no frame is being tracked, which includes the first rise after reset. It is also accepted when it is found on the same rising edge that takes bit 255 of the tracked frame.
- R6: If no sync rise is found on the edge that takes bit 255, that frame still completes and produces its outputs. Tracking then stops until the next sync rise, which is accepted whenever it comes.
- R7: When the frame-valid bit is 0, no strobe is raised for that frame, whatever its slot tags say.
- R8: `ctl_wr_o` pulses only when the tags of slot 1 and slot 2 are both 1. With that pulse, `ctl_addr_o` takes all 20 bits of slot 1 and `ctl_data_o` takes all 20 bits of slot 2.
- R9: The left strobe depends only on the slot 3 tag, and the right strobe only on the slot 4 tag. Each strobe loads bits 19..2 of its slot (the top 18 bits) onto its PCM output.
- R10: Slots 5 to 12 and their tags have no effect on any output.
- R11: Each strobe lasts exactly one cycle, and it rises only on the edge that takes bit 255 of an accepted frame. A data output keeps its value in every cycle in which its own strobe is low.
- R12: There is no back-pressure. During uninterrupted back-to-back frames, a strobe that is set in every frame repeats every 256 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; sync is sampled on its rising edge, data on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_i | input | 1 | Frame sync from the controller |
| sdata_i | input | 1 | Serial data from the controller |
| ctl_addr_o | output | 20 | Control address word (slot 1) |
| ctl_data_o | output | 20 | Control data word (slot 2) |
| ctl_wr_o | output | 1 | One-cycle control write strobe |
| pcm_left_o | output | 18 | Left sample, top 18 bits of slot 3 |
| pcm_left_stb_o | output | 1 | One-cycle left sample strobe |
| pcm_right_o | output | 18 | Right sample, top 18 bits of slot 4 |
| pcm_right_stb_o | output | 1 | One-cycle right sample strobe |

## Verification
The assertions assume that sync and data change only between a falling edge and the next rising edge, so that each is stable where it is sampled. They also assume that reset is held across at least one rising edge, so that every `$past` term sees reset values. The one-cycle strobe properties rely on accepted frames being at least 256 cycles apart, which the receiver itself guarantees. The stimulus therefore drives sync and data one nanosecond after each rising edge, holds reset for several cycles, and sends frames only through a task that places each bit on its own rising edge. Deliberately early sync rises are made by raising sync for a single cycle inside a frame.

// File: rtl/alr_pkg.sv
package alr_pkg;

  // Default link geometry.
  localparam int unsigned TAG_BITS   = 16;
  localparam int unsigned SLOT_BITS  = 20;
  localparam int unsigned NUM_SLOTS  = 12;
  localparam int unsigned FRAME_BITS = TAG_BITS + NUM_SLOTS * SLOT_BITS;
  localparam int unsigned SAMPLE_W   = 18;

  // Slots taken by the receiver, in slot order starting at slot 1.
  typedef enum int unsigned {
    ROLE_CTL_ADDR = 0,
    ROLE_CTL_DATA = 1,
    ROLE_PCM_L    = 2,
    ROLE_PCM_R    = 3
  } slot_role_e;

  localparam int unsigned NUM_TAKEN = 4;

endpackage

// File: rtl/alr_frame_tracker.sv
module alr_frame_tracker #(
  parameter int FRAME_BITS = 256,
  parameter int CW         = $clog2(FRAME_BITS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sync_i,
  output logic          bit_en_o,
  output logic [CW-1:0] bit_idx_o,
  output logic          frame_done_o
);

  localparam logic [CW-1:0] LAST_IDX = CW'(FRAME_BITS - 1);

  logic          sync_q;
  logic          locked;
  logic          clean;
  logic [CW-1:0] cnt;
  logic          rise;
  logic          last;

  assign rise = sync_i & ~sync_q;
  assign last = (cnt == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 1'b0;
      locked <= 1'b0;
      clean  <= 1'b0;
      cnt    <= '0;
    end else begin
      sync_q <= sync_i;
      if (!locked) begin
        if (rise) begin
          locked <= 1'b1;
          clean  <= 1'b1;
          cnt    <= '0;
        end
      end else if (last) begin
        cnt <= '0;
        if (rise) begin
          clean <= 1'b1;
        end else begin
          locked <= 1'b0;
          clean  <= 1'b0;
        end
      end else begin
        cnt <= cnt + 1'b1;
        if (rise) clean <= 1'b0;
      end
    end
  end

  // A bit is consumed on every edge of a tracked, unspoiled frame.
  assign bit_en_o     = locked & clean;
  assign bit_idx_o    = cnt;
  assign frame_done_o = locked & clean & last;

  AST_EARLY_RISE_SPOILS: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && rise && !last) |=> !clean); // R4

  AST_ON_TIME_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && rise && last) |=> (locked && clean && cnt == '0)); // R5

  AST_MISSED_START_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && last && !rise) |=> !locked); // R6

  AST_COUNT_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !last) |=> (cnt == $past(cnt) + 1'b1)); // R3

endmodule

// File: rtl/alr_slot_capture.sv
module alr_slot_capture #(
  parameter int TAG_W     = 16,
  parameter int SLOT_W    = 20,
  parameter int NUM_TAKE  = 4,
  parameter int CW        = 8
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             bit_en_i,
  input  logic [CW-1:0]                    bit_idx_i,
  input  logic                             sd_i,
  output logic                             fv_o,
  output logic [NUM_TAKE-1:0]              tag_o,
  output logic [NUM_TAKE-1:0][SLOT_W-1:0]  slot_o
);

  logic [SLOT_W-2:0] sh;
  logic [SLOT_W-1:0] word;
  logic              fv_q;
  logic [NUM_TAKE-1:0] tag_q;

  // MSB-first: the newest bit is the LSB of the word being assembled.
  assign word = {sh, sd_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '0;
      fv_q <= 1'b0;
    end else if (bit_en_i) begin
      sh <= word[SLOT_W-2:0];
      if (bit_idx_i == '0) fv_q <= sd_i;
    end
  end

  for (genvar g = 0; g < NUM_TAKE; g++) begin : g_take
    localparam int TAG_POS = g + 1;
    localparam int END_POS = TAG_W + (g + 1) * SLOT_W - 1;
    logic [SLOT_W-1:0] slot_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tag_q[g] <= 1'b0;
        slot_q   <= '0;
      end else if (bit_en_i) begin
        if (bit_idx_i == CW'(TAG_POS)) tag_q[g] <= sd_i;
        if (bit_idx_i == CW'(END_POS)) slot_q   <= word;
      end
    end

    assign slot_o[g] = slot_q;
  end

  assign fv_o  = fv_q;
  assign tag_o = tag_q;

  AST_TAGS_MOVE_ON_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tag_q) |-> $past(bit_en_i)); // R3

endmodule

// File: rtl/alr_out_stage.sv
module alr_out_stage #(
  parameter int SLOT_W   = 20,
  parameter int PCM_W    = 18,
  parameter int NUM_TAKE = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            done_i,
  input  logic                            fv_i,
  input  logic [NUM_TAKE-1:0]             tag_i,
  input  logic [NUM_TAKE-1:0][SLOT_W-1:0] slot_i,
  output logic [SLOT_W-1:0]               ctl_addr_o,
  output logic [SLOT_W-1:0]               ctl_data_o,
  output logic                            ctl_wr_o,
  output logic [1:0][PCM_W-1:0]           pcm_o,
  output logic [1:0]                      pcm_stb_o
);

  import alr_pkg::*;

  logic fire;
  assign fire = done_i & fv_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_addr_o <= '0;
      ctl_data_o <= '0;
      ctl_wr_o   <= 1'b0;
    end else begin
      ctl_wr_o <= 1'b0;
      if (fire && tag_i[ROLE_CTL_ADDR] && tag_i[ROLE_CTL_DATA]) begin
        ctl_wr_o   <= 1'b1;
        ctl_addr_o <= slot_i[ROLE_CTL_ADDR];
        ctl_data_o <= slot_i[ROLE_CTL_DATA];
      end
    end
  end

  for (genvar ch = 0; ch < 2; ch++) begin : g_pcm
    localparam int SLOT_IDX = ROLE_PCM_L + ch;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pcm_o[ch]     <= '0;
        pcm_stb_o[ch] <= 1'b0;
      end else begin
        pcm_stb_o[ch] <= 1'b0;
        if (fire && tag_i[SLOT_IDX]) begin
          pcm_stb_o[ch] <= 1'b1;
          pcm_o[ch]     <= slot_i[SLOT_IDX][SLOT_W-1 -: PCM_W];
        end
      end
    end

    AST_PCM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !pcm_stb_o[ch] |-> $stable(pcm_o[ch])); // R11

    AST_PCM_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      pcm_stb_o[ch] |=> !pcm_stb_o[ch]); // R11
  end

  AST_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr_o |=> !ctl_wr_o); // R11

  AST_CTL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_wr_o |-> ($stable(ctl_addr_o) && $stable(ctl_data_o))); // R11

endmodule

// File: rtl/serial_link_frame_rx.sv
module serial_link_frame_rx #(
  parameter int TAG_W     = alr_pkg::TAG_BITS,
  parameter int SLOT_W    = alr_pkg::SLOT_BITS,
  parameter int NUM_SLOTS = alr_pkg::NUM_SLOTS,
  parameter int PCM_W     = alr_pkg::SAMPLE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_i,
  input  logic              sdata_i,
  output logic [SLOT_W-1:0] ctl_addr_o,
  output logic [SLOT_W-1:0] ctl_data_o,
  output logic              ctl_wr_o,
  output logic [PCM_W-1:0]  pcm_left_o,
  output logic              pcm_left_stb_o,
  output logic [PCM_W-1:0]  pcm_right_o,
  output logic              pcm_right_stb_o
);

  localparam int FRAME_BITS = TAG_W + NUM_SLOTS * SLOT_W;
  localparam int CW         = $clog2(FRAME_BITS);
  localparam int NUM_TAKE   = alr_pkg::NUM_TAKEN;

  logic                            sd_fall;
  logic                            bit_en;
  logic [CW-1:0]                   bit_idx;
  logic                            frame_done;
  logic                            fv;
  logic [NUM_TAKE-1:0]             tags;
  logic [NUM_TAKE-1:0][SLOT_W-1:0] slots;
  logic [1:0][PCM_W-1:0]           pcm;
  logic [1:0]                      pcm_stb;

  // Data is captured on the falling edge and consumed on the next rising edge.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) sd_fall <= 1'b0;
    else        sd_fall <= sdata_i;
  end

  alr_frame_tracker #(
    .FRAME_BITS (FRAME_BITS),
    .CW         (CW)
  ) u_tracker (
    .clk          (clk),
    .rst_n        (rst_n),
    .sync_i       (sync_i),
    .bit_en_o     (bit_en),
    .bit_idx_o    (bit_idx),
    .frame_done_o (frame_done)
  );

  alr_slot_capture #(
    .TAG_W    (TAG_W),
    .SLOT_W   (SLOT_W),
    .NUM_TAKE (NUM_TAKE),
    .CW       (CW)
  ) u_capture (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_en_i  (bit_en),
    .bit_idx_i (bit_idx),
    .sd_i      (sd_fall),
    .fv_o      (fv),
    .tag_o     (tags),
    .slot_o    (slots)
  );

  alr_out_stage #(
    .SLOT_W   (SLOT_W),
    .PCM_W    (PCM_W),
    .NUM_TAKE (NUM_TAKE)
  ) u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .done_i     (frame_done),
    .fv_i       (fv),
    .tag_i      (tags),
    .slot_i     (slots),
    .ctl_addr_o (ctl_addr_o),
    .ctl_data_o (ctl_data_o),
    .ctl_wr_o   (ctl_wr_o),
    .pcm_o      (pcm),
    .pcm_stb_o  (pcm_stb)
  );

  assign pcm_left_o      = pcm[0];
  assign pcm_right_o     = pcm[1];
  assign pcm_left_stb_o  = pcm_stb[0];
  assign pcm_right_stb_o = pcm_stb[1];

  AST_STB_AT_FRAME_END: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr_o || pcm_left_stb_o || pcm_right_stb_o)
      |-> $past(bit_en && bit_idx == CW'(FRAME_BITS - 1))); // R11

endmodule

// File: tb/serial_link_frame_rx_bench.sv
module serial_link_frame_rx_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sync = 1'b0;
  logic        sdata = 1'b0;
  logic [19:0] ctl_addr, ctl_data;
  logic        ctl_wr;
  logic [17:0] pcm_l, pcm_r;
  logic        l_stb, r_stb;

  int  n_chk = 0;
  int  n_bad = 0;
  int  cyc = 0;
  int  start_cyc = 0;
  logic pend = 1'b0;

  int  wr_n = 0, l_n = 0, r_n = 0;
  int  wr_cyc = 0, l_cyc = 0, l_prev_cyc = 0;

  always #2 clk = ~clk;

  serial_link_frame_rx u_serial_link_frame_rx (
    .clk (clk), .rst_n (rst_n), .sync_i (sync), .sdata_i (sdata),
    .ctl_addr_o (ctl_addr), .ctl_data_o (ctl_data), .ctl_wr_o (ctl_wr),
    .pcm_left_o (pcm_l), .pcm_left_stb_o (l_stb),
    .pcm_right_o (pcm_r), .pcm_right_stb_o (r_stb)
  );

  always @(posedge clk) cyc = cyc + 1;

  always @(negedge clk) begin
    if (ctl_wr) begin wr_n = wr_n + 1; wr_cyc = cyc; end
    if (l_stb)  begin l_n = l_n + 1; l_prev_cyc = l_cyc; l_cyc = cyc; end
    if (r_stb)  r_n = r_n + 1;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // tags[k] is the tag of slot k+1; f[255-i] holds frame bit i.
  function automatic logic [255:0] mk(input logic fv, input logic [11:0] tags,
      input logic [19:0] s1, input logic [19:0] s2, input logic [19:0] s3,
      input logic [19:0] s4, input logic [19:0] other);
    logic [255:0] f = '0;
    f[255] = fv;
    for (int n = 1; n <= 12; n++) f[255-n] = tags[n-1];
    for (int n = 1; n <= 12; n++) begin
      logic [19:0] v;
      case (n)
        1: v = s1; 2: v = s2; 3: v = s3; 4: v = s4;
        default: v = other ^ 20'(n);
      endcase
      for (int b = 0; b < 20; b++) f[255-(16+20*(n-1)+b)] = v[19-b];
    end
    return f;
  endfunction

  task automatic run_frame(input logic [255:0] f, input int rogue_at);
    for (int j = 0; j < 256; j++) begin
      @(posedge clk); #1;
      if (j == 0) begin
        start_cyc = cyc;
        sdata = pend;
      end else begin
        sdata = f[256-j];
      end
      sync = (j < 16) || (rogue_at != 0 && j == rogue_at);
    end
    pend = f[0];
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #1;
      sdata = (k == 0) ? pend : 1'b0;
      sync = 1'b0;
    end
    pend = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!ctl_wr && !l_stb && !r_stb, "R1 strobes", {ctl_wr, l_stb, r_stb}, 0);
    chk(ctl_addr == 0 && ctl_data == 0, "R1 ctl", {ctl_addr, ctl_data}, 0);
    chk(pcm_l == 0 && pcm_r == 0, "R1 pcm", {pcm_l, pcm_r}, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    idle(3);
    chk(wr_n == 0 && l_n == 0, "R1 quiet after release", wr_n + l_n, 0);
  endtask

  task automatic t_basic();
    logic [19:0] a = 20'h9C3A5, d = 20'h0F1E2, l = 20'hB6D49, r = 20'h4A7F3;
    run_frame(mk(1'b1, 12'h00F, a, d, l, r, 20'h55555), 0);
    idle(4);
    chk(wr_n == 1, "R8 write pulse", wr_n, 1);
    chk(ctl_addr == a, "R3 slot1 MSB first", ctl_addr, a);
    chk(ctl_data == d, "R8 ctl data", ctl_data, d);
    chk(l_n == 1 && pcm_l == l[19:2], "R9 left", pcm_l, l[19:2]);
    chk(r_n == 1 && pcm_r == r[19:2], "R9 right", pcm_r, r[19:2]);
    chk(wr_cyc - start_cyc == 257, "R2 output timing", wr_cyc - start_cyc, 257);
    chk(l_cyc == wr_cyc, "R11 together", l_cyc, wr_cyc);
  endtask

  task automatic t_invalid_frame();
    int w = wr_n, ln = l_n, rn = r_n;
    run_frame(mk(1'b0, 12'hFFF, 20'h11111, 20'h22222, 20'h33333, 20'h44444, 0), 0);
    idle(4);
    chk(wr_n == w && l_n == ln && r_n == rn, "R7 no strobe", wr_n + l_n + r_n, w + ln + rn);
    chk(ctl_addr == 20'h9C3A5, "R7 ctl held", ctl_addr, 20'h9C3A5);
  endtask

  task automatic t_partial_tags();
    int w = wr_n, ln = l_n, rn = r_n;
    logic [17:0] r_old = pcm_r;
    run_frame(mk(1'b1, 12'h005, 20'hAAAAA, 20'hBBBBB, 20'h6E0C7, 20'hDDDDD, 0), 0);
    idle(4);
    chk(wr_n == w, "R8 needs both tags", wr_n, w);
    chk(ctl_addr == 20'h9C3A5, "R11 ctl held", ctl_addr, 20'h9C3A5);
    chk(l_n == ln + 1 && pcm_l == 18'(20'h6E0C7 >> 2), "R9 left alone", pcm_l, 20'h6E0C7 >> 2);
    chk(r_n == rn && pcm_r == r_old, "R9 right held", pcm_r, r_old);
  endtask

  task automatic t_other_slots();
    int w = wr_n, ln = l_n, rn = r_n;
    logic [17:0] l_old = pcm_l;
    run_frame(mk(1'b1, 12'hFF0, 20'h12345, 20'h23456, 20'h34567, 20'h45678, 20'hFFFFF), 0);
    idle(4);
    chk(wr_n == w && l_n == ln && r_n == rn, "R10 no strobe", wr_n + l_n + r_n, w + ln + rn);
    chk(pcm_l == l_old, "R10 outputs held", pcm_l, l_old);
  endtask

  task automatic t_early_sync();
    int ln = l_n;
    run_frame(mk(1'b1, 12'h00F, 20'h1, 20'h2, 20'hCCCC8, 20'h4, 0), 120);
    run_frame(mk(1'b1, 12'h00F, 20'h5, 20'h6, 20'h3A5C4, 20'h8, 0), 0);
    idle(4);
    chk(l_n == ln + 1, "R4 spoiled frame silent", l_n, ln + 1);
    chk(pcm_l == 18'(20'h3A5C4 >> 2), "R5 on-time start taken", pcm_l, 20'h3A5C4 >> 2);
    chk(ctl_addr == 20'h5, "R4 spoiled ctl dropped", ctl_addr, 20'h5);
  endtask

  task automatic t_lock_loss();
    int ln = l_n;
    run_frame(mk(1'b1, 12'h004, 0, 0, 20'h11110, 0, 0), 0);
    idle(37);
    chk(l_n == ln + 1 && pcm_l == 18'(20'h11110 >> 2), "R6 last frame kept", pcm_l, 20'h11110 >> 2);
    run_frame(mk(1'b1, 12'h004, 0, 0, 20'h7777C, 0, 0), 0);
    idle(4);
    chk(l_n == ln + 2 && pcm_l == 18'(20'h7777C >> 2), "R6 relock any time", pcm_l, 20'h7777C >> 2);
  endtask

  task automatic t_back_to_back();
    int ln = l_n;
    run_frame(mk(1'b1, 12'h004, 0, 0, 20'h10000, 0, 0), 0);
    run_frame(mk(1'b1, 12'h004, 0, 0, 20'h20000, 0, 0), 0);
    run_frame(mk(1'b1, 12'h004, 0, 0, 20'h30004, 0, 0), 0);
    idle(4);
    chk(l_n == ln + 3, "R5 three frames", l_n, ln + 3);
    chk(l_cyc - l_prev_cyc == 256, "R12 spacing", l_cyc - l_prev_cyc, 256);
    chk(pcm_l == 18'(20'h30004 >> 2), "R12 last value", pcm_l, 20'h30004 >> 2);
  endtask

  bit done = 1'b0;

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_basic();
    t_invalid_frame();
    t_partial_tags();
    t_other_slots();
    t_early_sync();
    t_lock_loss();
    t_back_to_back();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule